// File: doc/BRIEF.md
# Peripheral Interrupt Accumulator

This block gathers interrupt requests from a set of peripherals, each addressed by an index and each driving a small group of request lines. Each line sets a sticky status bit. A bit stays set until software clears it by writing a one to that bit position. Each peripheral also has a single enable bit. The block keeps a second, coarser level of pending state. Summary words pack one bit per peripheral, 32 peripherals per word, and a peripheral's bit reads as one only while it is enabled and holds at least one pending line.

All summary bits are combined into one registered interrupt output. A priority encoder reports the lowest-numbered pending peripheral, so a handler can go straight to it without scanning the summary words. Software uses a flat register bus with a write strobe. Reads are combinational from the address.

The address map is fixed:

| Region | Address | Access | Contents |
|---|---|---|---|
| Summary word w | 0x000 + 4*w | read-only | bit b is peripheral 32*w + b |
| Enable of peripheral p | 0x200 + 4*p | read/write | enable in bit 0 |
| Status of peripheral p | 0x600 + 4*p | read-only | bit n is line n |
| Clear of peripheral p | 0xA00 + 4*p | write-only | a one in bit n clears line n |

Top module: `periph_irq_accum`

## Requirements
- R1: Synchronous active-low reset sets every status bit and every enable bit to 0 and sets irq_out to 0. After reset, every register read returns 0 and pend_valid is 0.
- R2: When irq_in bit p*NL+n is high at a clock edge, status bit n of peripheral p is set. The read at 0x600+4*p shows the set bit from the next cycle on, and the bit stays set after irq_in falls.
- R3: A write to 0xA00+4*p clears exactly those status bits of peripheral p whose bit positions hold a 1 in bus_wdata. Bit positions that hold a 0 keep their status bits.
- R4: When a line's set request and its clear arrive in the same cycle, the status bit ends up set.
- R5: A write to 0x200+4*p loads bus_wdata bit 0 into the enable of peripheral p. A read of that address returns the enable in bit 0 and zeros in all other bits.
- R6: Bit b of the summary word at 0x000+4*w is 1 exactly when peripheral 32*w+b is enabled and has a nonzero status. Status bits still latch while the peripheral is disabled.
- R7: irq_out equals, one cycle late, the OR of all summary bits.
- R8: pend_valid is 1 exactly when any summary bit is set. While pend_valid is 1, pend_idx gives the lowest peripheral index whose summary bit is set.
- R9: Writes to the summary and status regions change nothing. Reads of the clear region and of unmapped addresses (such as 0x100 and 0xE00) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NP*NL | Set requests; bit p*NL+n drives line n of peripheral p |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Registered combined interrupt |
| pend_valid | output | 1 | Some enabled peripheral has a pending line |
| pend_idx | output | $clog2(NP) | Lowest pending peripheral index |

## Verification
Status and enable updates take effect at the clock edge that samples the set request or the write. Read data, the summary words and the encoder outputs then follow combinationally in the same cycle. irq_out follows one edge later still. The bench drives every input at a falling edge and checks the read data 1 ns later, against a model of the state before the coming edge. It then applies the edge to its model and checks irq_out, pend_valid and pend_idx at the next falling edge. irq_out is compared with the summary OR taken before that edge.

// File: rtl/pia_pkg.sv
// Shared address map and region codes for the peripheral interrupt accumulator.
// Assumes a 12-bit byte address and 32-bit data bus.
package pia_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int SUM_BASE = 'h000;
    localparam int EN_BASE  = 'h200;
    localparam int ST_BASE  = 'h600;
    localparam int CL_BASE  = 'hA00;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SUM,
        RG_EN,
        RG_ST,
        RG_CL
    } region_e;
endpackage

// File: rtl/pia_decode.sv
// Address decoder: classifies the bus address into a region, extracts the
// peripheral index and summary word number, and forms the per-peripheral
// enable strobes and clear masks. Assumes NP <= 256 and NP a multiple of 32.
module pia_decode #(
    parameter int NP = 256,
    parameter int NL = 8
) (
    input  logic                          bus_we,
    input  logic [pia_pkg::ADDR_W-1:0]    bus_addr,
    input  logic [pia_pkg::DATA_W-1:0]    bus_wdata,
    output pia_pkg::region_e              region,
    output logic [$clog2(NP)-1:0]         idx,
    output logic [((NP/32)>1 ? $clog2(NP/32) : 1)-1:0] word,
    output logic [NP-1:0]                 en_we,
    output logic                          en_val,
    output logic [NP*NL-1:0]              clr_flat
);
    localparam int IW = $clog2(NP);
    localparam int NW = NP / 32;
    localparam int WW = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [12:0] SUM_HI = 13'(pia_pkg::SUM_BASE + 4 * NW);
    localparam logic [12:0] EN_LO  = 13'(pia_pkg::EN_BASE);
    localparam logic [12:0] EN_HI  = 13'(pia_pkg::EN_BASE + 4 * NP);
    localparam logic [12:0] ST_LO  = 13'(pia_pkg::ST_BASE);
    localparam logic [12:0] ST_HI  = 13'(pia_pkg::ST_BASE + 4 * NP);
    localparam logic [12:0] CL_LO  = 13'(pia_pkg::CL_BASE);
    localparam logic [12:0] CL_HI  = 13'(pia_pkg::CL_BASE + 4 * NP);

    logic [12:0] addr_x;
    logic [11:0] off;

    assign addr_x = {1'b0, bus_addr};

    // Region classification by address range.
    always_comb begin
        if (addr_x < SUM_HI)                        region = pia_pkg::RG_SUM;
        else if (addr_x >= EN_LO && addr_x < EN_HI) region = pia_pkg::RG_EN;
        else if (addr_x >= ST_LO && addr_x < ST_HI) region = pia_pkg::RG_ST;
        else if (addr_x >= CL_LO && addr_x < CL_HI) region = pia_pkg::RG_CL;
        else                                        region = pia_pkg::RG_NONE;
    end

    // Offset inside the selected peripheral region.
    always_comb begin
        case (region)
            pia_pkg::RG_EN: off = bus_addr - 12'(pia_pkg::EN_BASE);
            pia_pkg::RG_ST: off = bus_addr - 12'(pia_pkg::ST_BASE);
            pia_pkg::RG_CL: off = bus_addr - 12'(pia_pkg::CL_BASE);
            default:        off = '0;
        endcase
    end

    assign idx    = off[IW+1:2];
    assign word   = bus_addr[WW+1:2];
    assign en_val = bus_wdata[0];

    // Per-peripheral write strobes and clear masks.
    for (genvar p = 0; p < NP; p++) begin : g_strobe
        assign en_we[p] = bus_we && (region == pia_pkg::RG_EN) && (idx == IW'(p));
        assign clr_flat[p*NL +: NL] =
            (bus_we && (region == pia_pkg::RG_CL) && (idx == IW'(p))) ? bus_wdata[NL-1:0] : '0;
    end
endmodule

// File: rtl/pia_line_bank.sv
// Storage for the sticky per-line status bits and per-peripheral enables.
// A set request beats a clear of the same bit in the same cycle.
module pia_line_bank #(
    parameter int NP = 256,
    parameter int NL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP*NL-1:0] set_flat,
    input  logic [NP*NL-1:0] clr_flat,
    input  logic [NP-1:0]    en_we,
    input  logic             en_val,
    output logic [NP*NL-1:0] status_flat,
    output logic [NP-1:0]    enable_vec
);
    for (genvar p = 0; p < NP; p++) begin : g_periph
        // Status byte: clear first, then OR in new requests.
        always_ff @(posedge clk) begin
            if (!rst_n) status_flat[p*NL +: NL] <= '0;
            else        status_flat[p*NL +: NL] <= (status_flat[p*NL +: NL] & ~clr_flat[p*NL +: NL])
                                                   | set_flat[p*NL +: NL];
        end

        // Enable bit: loaded on its own write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)         enable_vec[p] <= 1'b0;
            else if (en_we[p])  enable_vec[p] <= en_val;
        end
    end
endmodule

// File: rtl/pia_summary.sv
// Forms one summary bit per peripheral: enabled and any line pending.
module pia_summary #(
    parameter int NP = 256,
    parameter int NL = 8
) (
    input  logic [NP*NL-1:0] status_flat,
    input  logic [NP-1:0]    enable_vec,
    output logic [NP-1:0]    summary_vec,
    output logic             summary_any
);
    for (genvar p = 0; p < NP; p++) begin : g_sum
        assign summary_vec[p] = enable_vec[p] & (|status_flat[p*NL +: NL]);
    end
    assign summary_any = |summary_vec;
endmodule

// File: rtl/pia_lowest.sv
// Priority encoder returning the lowest set bit position and a valid flag.
module pia_lowest #(
    parameter int N = 256
) (
    input  logic [N-1:0]         req,
    output logic [$clog2(N)-1:0] idx,
    output logic                 valid
);
    localparam int IW = $clog2(N);

    // Scan from the top so the lowest set bit is assigned last.
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IW'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/periph_irq_accum.sv
// Top of the peripheral interrupt accumulator: decoder, line bank, summary,
// lowest-index encoder, read mux and registered combined interrupt.
// Assumes NP is a multiple of 32, NP <= 256, NL <= 32.
module periph_irq_accum #(
    parameter int NP = 256,
    parameter int NL = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP*NL-1:0]     irq_in,
    input  logic                 bus_we,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq_out,
    output logic                 pend_valid,
    output logic [$clog2(NP)-1:0] pend_idx
);
    localparam int IW = $clog2(NP);
    localparam int NW = NP / 32;
    localparam int WW = (NW > 1) ? $clog2(NW) : 1;

    pia_pkg::region_e region;
    logic [IW-1:0]    idx;
    logic [WW-1:0]    word;
    logic [NP-1:0]    en_we;
    logic             en_val;
    logic [NP*NL-1:0] clr_flat;
    logic [NP*NL-1:0] status_flat;
    logic [NP-1:0]    enable_vec;
    logic [NP-1:0]    summary_vec;
    logic             summary_any;

    pia_decode #(.NP(NP), .NL(NL)) u_dec (
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .region(region), .idx(idx), .word(word),
        .en_we(en_we), .en_val(en_val), .clr_flat(clr_flat)
    );

    pia_line_bank #(.NP(NP), .NL(NL)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_flat(irq_in), .clr_flat(clr_flat),
        .en_we(en_we), .en_val(en_val),
        .status_flat(status_flat), .enable_vec(enable_vec)
    );

    pia_summary #(.NP(NP), .NL(NL)) u_sum (
        .status_flat(status_flat), .enable_vec(enable_vec),
        .summary_vec(summary_vec), .summary_any(summary_any)
    );

    pia_lowest #(.N(NP)) u_enc (
        .req(summary_vec), .idx(pend_idx), .valid(pend_valid)
    );

    // Read mux: region-selected register contents, zero elsewhere.
    always_comb begin
        case (region)
            pia_pkg::RG_SUM: bus_rdata = summary_vec[{word, 5'b0} +: 32];
            pia_pkg::RG_EN:  bus_rdata = {31'b0, enable_vec[idx]};
            pia_pkg::RG_ST:  bus_rdata = 32'(status_flat[idx*NL +: NL]);
            default:         bus_rdata = '0;
        endcase
    end

    // Combined interrupt, registered one cycle behind the summary.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= summary_any;
    end
endmodule

// File: rtl/periph_irq_accum_chk.sv
// Checker for the accumulator: relates request/clear inputs to the status
// store, and summary, encoder and interrupt outputs to each other.
module periph_irq_accum_chk #(
    parameter int NP = 256,
    parameter int NL = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NP*NL-1:0]      irq_in,
    input logic [NP*NL-1:0]      clr_flat,
    input logic [NP*NL-1:0]      status_flat,
    input logic [NP-1:0]         enable_vec,
    input logic [NP-1:0]         summary_vec,
    input logic                  irq_out,
    input logic                  pend_valid,
    input logic [$clog2(NP)-1:0] pend_idx
);
    logic [NP-1:0] below_mask;
    assign below_mask = (NP'(1) << pend_idx) - NP'(1);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_flat & $past(irq_in)) == $past(irq_in)));                  // R4
    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_flat) & ~status_flat & ~$past(clr_flat)) == '0));    // R3
    AST_SUMMARY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((summary_vec & ~enable_vec) == '0));                                       // R6
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(pend_valid)));                                   // R7
    AST_PEND_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> summary_vec[pend_idx]);                                      // R8
    AST_PEND_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ((summary_vec & below_mask) == '0));                         // R8
    AST_PEND_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> (summary_vec == '0));                                       // R8
endmodule

bind periph_irq_accum periph_irq_accum_chk #(.NP(NP), .NL(NL)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_flat(clr_flat),
    .status_flat(status_flat), .enable_vec(enable_vec), .summary_vec(summary_vec),
    .irq_out(irq_out), .pend_valid(pend_valid), .pend_idx(pend_idx)
);

// File: tb/periph_irq_accum_test.sv
// Bench: directed corner cases then seeded random traffic against a model.
module periph_irq_accum_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 256;
    localparam int NL = 8;
    localparam int NW = NP / 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP*NL-1:0] irq_in = '0;
    logic             bus_we = 1'b0;
    logic [11:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             irq_out;
    logic             pend_valid;
    logic [7:0]       pend_idx;

    logic [NP*NL-1:0] irq_drv = '0;
    logic [7:0]       m_st [NP];
    logic             m_en [NP];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    periph_irq_accum #(.NP(NP), .NL(NL)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .pend_valid(pend_valid), .pend_idx(pend_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit f_pend(input int p);
        return m_en[p] && (m_st[p] != 8'h00);
    endfunction

    function automatic bit f_any();
        for (int p = 0; p < NP; p++) if (f_pend(p)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int f_low();
        for (int p = 0; p < NP; p++) if (f_pend(p)) return p;
        return 0;
    endfunction

    function automatic logic [31:0] f_read(input logic [11:0] a);
        logic [31:0] r = '0;
        if (a < 12'(4*NW)) begin
            for (int b = 0; b < 32; b++) r[b] = f_pend(int'(a[11:2])*32 + b);
        end else if (a >= 12'h200 && a < 12'h600) r = {31'b0, m_en[(a - 12'h200) >> 2]};
        else if (a >= 12'h600 && a < 12'hA00)     r = {24'b0, m_st[(a - 12'h600) >> 2]};
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle starting at a falling edge: drive, check read, apply edge, check outputs.
    task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] wd,
                       input logic [31:0] exp_rd, input string tag);
        bit exp_irq;
        irq_in = irq_drv; bus_we = we; bus_addr = a; bus_wdata = wd;
        #1;
        chk(bus_rdata == exp_rd, tag, bus_rdata, exp_rd);
        exp_irq = f_any();
        @(posedge clk);
        for (int p = 0; p < NP; p++) begin
            logic [7:0] clr = '0;
            if (we && a >= 12'hA00 && a < 12'hE00 && int'((a - 12'hA00) >> 2) == p) clr = wd[7:0];
            m_st[p] = (m_st[p] & ~clr) | irq_drv[p*NL +: NL];
            if (we && a >= 12'h200 && a < 12'h600 && int'((a - 12'h200) >> 2) == p) m_en[p] = wd[0];
        end
        @(negedge clk);
        chk(irq_out == exp_irq, "R7 irq_out", 32'(irq_out), 32'(exp_irq));
        chk(pend_valid == f_any(), "R8 pend_valid", 32'(pend_valid), 32'(f_any()));
        if (f_any()) chk(pend_idx == 8'(f_low()), "R8 pend_idx", 32'(pend_idx), 32'(f_low()));
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, a, 32'h0, exp, tag);
    endtask

    function automatic int pick();
        case ($urandom % 3)
            0:       return $urandom % 8;
            1:       return 30 + ($urandom % 4);
            default: return 250 + ($urandom % 6);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++) begin m_st[p] = '0; m_en[p] = 1'b0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(irq_out == 1'b0, "R1 irq_out", 32'(irq_out), 0);
        chk(pend_valid == 1'b0, "R1 pend_valid", 32'(pend_valid), 0);
        rd(12'h600, 0, "R1 status");
        rd(12'h200, 0, "R1 enable");
        rd(12'h000, 0, "R1 summary");
        // R2: lines 1 and 3 of peripheral 5 latch, disabled so summary stays 0
        irq_drv[5*NL+3] = 1'b1; irq_drv[5*NL+1] = 1'b1;
        rd(12'h614, 0, "R2 before edge");
        irq_drv = '0;
        rd(12'h614, 32'h0A, "R2 latched");
        rd(12'h000, 0, "R6 disabled hidden");
        // R5: enable peripheral 5
        cyc(1'b1, 12'h214, 32'hFFFF_FFFF, 0, "R5 pre");
        rd(12'h214, 32'h1, "R5 readback");
        rd(12'h000, 32'h20, "R6 word0");
        chk(pend_idx == 8'd5, "R8 idx5", 32'(pend_idx), 5);
        // peripheral 37 set and enabled in the same cycle
        irq_drv[37*NL] = 1'b1;
        cyc(1'b1, 12'h294, 32'h1, 0, "R5 pre37");
        irq_drv = '0;
        rd(12'h004, 32'h20, "R6 word1");
        chk(pend_idx == 8'd5, "R8 lowest", 32'(pend_idx), 5);
        // R3: clear line 3 only, then line 1
        cyc(1'b1, 12'hA14, 32'h08, 0, "R9 clear reads 0");
        rd(12'h614, 32'h02, "R3 partial");
        cyc(1'b1, 12'hA14, 32'h02, 0, "R9 clear reads 0");
        rd(12'h614, 32'h00, "R3 full");
        chk(pend_idx == 8'd37, "R8 idx37", 32'(pend_idx), 37);
        // R4: set and clear of the same line together
        irq_drv[37*NL+2] = 1'b1;
        cyc(1'b1, 12'hA94, 32'h04, 0, "R4 pre");
        irq_drv = '0;
        rd(12'h694, 32'h05, "R4 set wins");
        // R9: writes to read-only regions and unmapped reads
        cyc(1'b1, 12'h694, 32'h0, 32'h05, "R9 pre");
        rd(12'h694, 32'h05, "R9 status write ignored");
        cyc(1'b1, 12'h004, 32'h0, 32'h20, "R9 pre");
        rd(12'h004, 32'h20, "R9 summary write ignored");
        rd(12'hE00, 0, "R9 unmapped high");
        rd(12'h100, 0, "R9 unmapped low");
        // R6: disable 37, status still latched
        cyc(1'b1, 12'h294, 32'h0, 32'h1, "R5 pre");
        rd(12'h004, 0, "R6 gated off");
        rd(12'h694, 32'h05, "R6 status kept");
        // Random traffic
        for (int it = 0; it < 2000; it++) begin
            logic [11:0] a;
            logic [11:0] ra;
            logic        we;
            logic [31:0] wd;
            int p;
            irq_drv = '0;
            if ($urandom % 3 == 0) irq_drv[pick()*NL + ($urandom % NL)] = 1'b1;
            if ($urandom % 4 == 0) irq_drv[pick()*NL + ($urandom % NL)] = 1'b1;
            p = pick();
            we = 1'b0; a = 12'h000; wd = $urandom;
            case ($urandom % 6)
                0, 1: begin we = 1'b1; a = 12'h200 + 12'(4*p); end
                2, 3: begin we = 1'b1; a = 12'hA00 + 12'(4*p); end
                4:    begin we = 1'b1; a = ($urandom % 2) ? 12'h600 + 12'(4*p) : 12'(4*($urandom % NW)); end
                default: we = 1'b0;
            endcase
            case ($urandom % 3)
                0: ra = 12'h600 + 12'(4*pick());
                1: ra = 12'h200 + 12'(4*pick());
                default: ra = 12'(4*($urandom % NW));
            endcase
            if (!we) a = ra;
            cyc(we, a, wd, f_read(a), "R2/R5/R6 random read");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule